// File: doc/BRIEF.md
# Shared-Ramp Wilkinson Conversion Sequencer

This block runs a Wilkinson-style conversion for a bank of entries that all share one ramp and one counter. The entries are laid out as a number of channels times a number of quantities per channel. Examples of quantities are the fast and slow time-over-threshold values, two time-of-arrival values, and the high-gain and low-gain charge samples. Each entry has its own comparator. That comparator flips once the shared ramp passes the analog level held for that entry.

An external start request clears the counter and raises the ramp enable. The counter then advances on every clock. Each comparator passes through a two-flop synchronizer. When a synchronized rising edge is seen, the entry stores the counter value minus the synchronizer delay. This recovers the count that was current when the comparator actually crossed. After terminal count the ramp is dropped. The sequencer then waits two flush cycles so that crossings near the top of the scale still get stored, and then raises done. Results are read through a plain address/data port.

Top module: `wilkinson_seq`

## Requirements
- R1: After reset, rampEn, busy and done are low and every result reads full scale (2^CNT_W-1).
- R2: A start request sampled while not busy starts a conversion: in the next cycle rampEn and busy are high and the counter is 0.
- R3: rampEn stays high for exactly 2^CNT_W cycles, while the count goes 0 to 2^CNT_W-1. It then falls while busy stays high.
- R4: An entry whose comparator goes from low to high during the cycle in which the count equals c reads c after the conversion. This holds for every c from 0 to 2^CNT_W-1, including both ends of the scale.
- R5: Only the first low-to-high comparator transition in a conversion is stored. Later falls and rises of that comparator leave the result unchanged.
- R6: An entry with no low-to-high transition during the count reads 2^CNT_W-1. This includes a comparator that is already high when the conversion starts.
- R7: done goes high, and busy low, in the third cycle after the last rampEn cycle. done stays high until the next accepted start.
- R8: A start request while busy is ignored: the conversion's timing and results are unchanged.
- R9: rdData shows the result of entry rdAddr, where entry index = channel*NUM_QTY + quantity. It is combinational from rdAddr.
- R10: An accepted start clears done and presets every result to full scale in the first counting cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | External conversion trigger |
| cmpIn | input | NUM_CH*NUM_QTY | Per-entry comparator outputs (asynchronous) |
| rdAddr | input | $clog2(NUM_CH*NUM_QTY) | Result readout address |
| rdData | output | CNT_W | Result of the addressed entry |
| rampEn | output | 1 | Ramp run enable |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Results ready |

## Verification
The bench builds the block with 2 channels, 3 quantities per channel and a 6-bit counter. A full conversion therefore takes 64 counting cycles plus the flush. This makes both ends of the scale easy to reach: crossings at count 0, count 1, and exactly at terminal count. The last of these is stored only during the flush cycles. The small entry count also lets every result be read back after each conversion. The same scenarios cover the glitching comparator, the comparator that is high before start, and the start pulse that arrives during a run.

// File: rtl/wilk_pkg.sv
package wilk_pkg;

  // Number of synchronizer flops in front of each comparator; the
  // captured count is reduced by this amount.
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FLUSH,
    ST_DONE
  } wilkState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrCnt;   // zero the shared counter
    logic incCnt;   // advance the shared counter
    logic capEn;    // capture window open
    logic preset;   // load full scale into all results
  } wilkStrobe_t;

endpackage

// File: rtl/wilk_sync.sv
module wilk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= '0;
    else       shReg <= {shReg[STAGES-2:0], d};
  end

  assign q = shReg[STAGES-1];

endmodule

// File: rtl/wilk_ctrl.sv
module wilk_ctrl
  import wilk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        cntAtTop,
  input  logic        cntAtEnd,
  output wilkStrobe_t strb,
  output logic        rampEn,
  output logic        busy,
  output logic        done
);

  wilkState_t state, stateNxt;
  logic       accept;

  // A start is taken only from IDLE or DONE
  assign accept = startReq && ((state == ST_IDLE) || (state == ST_DONE));

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:  if (accept)   stateNxt = ST_RUN;
      ST_RUN:   if (cntAtTop) stateNxt = ST_FLUSH;
      ST_FLUSH: if (cntAtEnd) stateNxt = ST_DONE;
      ST_DONE:  if (accept)   stateNxt = ST_RUN;
      default:                stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    strb        = '0;
    strb.clrCnt = accept;
    strb.preset = accept;
    strb.incCnt = (state == ST_RUN) || (state == ST_FLUSH);
    strb.capEn  = (state == ST_RUN) || (state == ST_FLUSH);
  end

  assign rampEn = (state == ST_RUN);
  assign busy   = (state == ST_RUN) || (state == ST_FLUSH);
  assign done   = (state == ST_DONE);

endmodule

// File: rtl/wilk_datapath.sv
module wilk_datapath
  import wilk_pkg::*;
#(
  parameter int unsigned CNT_W   = 12,
  parameter int unsigned NUM_ENT = 384,
  parameter int unsigned ADDR_W  = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  wilkStrobe_t        strb,
  input  logic [NUM_ENT-1:0] cmpIn,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [CNT_W-1:0]   rdData,
  output logic               cntAtTop,
  output logic               cntAtEnd
);

  localparam logic [CNT_W:0]   TOP_VAL  = (CNT_W+1)'((1 << CNT_W) - 1);
  localparam logic [CNT_W:0]   END_VAL  = TOP_VAL + (CNT_W+1)'(SYNC_STAGES);
  localparam logic [CNT_W:0]   LAT_VAL  = (CNT_W+1)'(SYNC_STAGES);
  localparam logic [CNT_W-1:0] FULL_SCL = '1;

  // Shared counter, one bit wider so it can run through the flush cycles
  logic [CNT_W:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (strb.clrCnt) cnt <= '0;
    else if (strb.incCnt) cnt <= cnt + 1'b1;
  end

  assign cntAtTop = (cnt == TOP_VAL);
  assign cntAtEnd = (cnt == END_VAL);

  // Delay-compensated count and capture window
  logic [CNT_W:0]   cntComp;
  logic [CNT_W-1:0] capVal;
  logic             inWindow;

  assign cntComp  = cnt - LAT_VAL;
  assign capVal   = cntComp[CNT_W-1:0];
  assign inWindow = strb.capEn && (cnt >= LAT_VAL);

  // Per-entry synchronizer, edge detect and result register
  logic [NUM_ENT-1:0] syncQ;
  logic [NUM_ENT-1:0] prevQ;
  logic [NUM_ENT-1:0] rise;
  logic [NUM_ENT-1:0] got;
  logic [CNT_W-1:0]   res [NUM_ENT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= syncQ;
  end

  assign rise = syncQ & ~prevQ;

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    wilk_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rstN (rstN),
      .d    (cmpIn[e]),
      .q    (syncQ[e])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        res[e] <= FULL_SCL;
        got[e] <= 1'b0;
      end else if (strb.preset) begin
        res[e] <= FULL_SCL;
        got[e] <= 1'b0;
      end else if (inWindow && rise[e] && !got[e]) begin
        res[e] <= capVal;
        got[e] <= 1'b1;
      end
    end
  end

  always_comb begin
    if (32'(rdAddr) < NUM_ENT) rdData = res[rdAddr];
    else                       rdData = '0;
  end

endmodule

// File: rtl/wilkinson_seq.sv
module wilkinson_seq
  import wilk_pkg::*;
#(
  parameter int unsigned NUM_CH  = 64,
  parameter int unsigned NUM_QTY = 6,
  parameter int unsigned CNT_W   = 12
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  startReq,
  input  logic [NUM_CH*NUM_QTY-1:0]             cmpIn,
  input  logic [$clog2(NUM_CH*NUM_QTY)-1:0]     rdAddr,
  output logic [CNT_W-1:0]                      rdData,
  output logic                                  rampEn,
  output logic                                  busy,
  output logic                                  done
);

  localparam int unsigned NUM_ENT = NUM_CH * NUM_QTY;
  localparam int unsigned ADDR_W  = $clog2(NUM_ENT);

  wilkStrobe_t strb;
  logic        cntAtTop;
  logic        cntAtEnd;

  wilk_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .cntAtTop (cntAtTop),
    .cntAtEnd (cntAtEnd),
    .strb     (strb),
    .rampEn   (rampEn),
    .busy     (busy),
    .done     (done)
  );

  wilk_datapath #(
    .CNT_W   (CNT_W),
    .NUM_ENT (NUM_ENT),
    .ADDR_W  (ADDR_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cmpIn    (cmpIn),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .cntAtTop (cntAtTop),
    .cntAtEnd (cntAtEnd)
  );

endmodule

// File: rtl/wilk_seq_chk.sv
module wilk_seq_chk (
  input logic clk,
  input logic rstN,
  input logic startReq,
  input logic rampEn,
  input logic busy,
  input logic done
);

  // R2
  start_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy) |=> (rampEn && busy && !done));

  // R3
  ramp_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    rampEn |-> busy);

  // R3
  ramp_fall_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rampEn) |-> busy);

  // R7
  done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy));

  // R7
  busy_end_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && rampEn) |=> busy);

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !startReq) |=> done);

endmodule

bind wilkinson_seq wilk_seq_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .startReq (startReq),
  .rampEn   (rampEn),
  .busy     (busy),
  .done     (done)
);

// File: tb/sim_wilkinson_seq.sv
module sim_wilkinson_seq;

  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 2;
  localparam int NQ   = 3;
  localparam int CW   = 6;
  localparam int NE   = NCH * NQ;
  localparam int AW   = $clog2(NE);
  localparam int MAXV = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic [NE-1:0] cmpIn = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [CW-1:0] rdData;
  logic          rampEn, busy, done;

  int checks = 0;
  int errors = 0;

  // Per-entry stimulus: crossing count (-1 none, -2 high before start),
  // optional fall and re-rise counts (-1 none)
  int tgt   [NE];
  int fallK [NE];
  int riseK [NE];

  wilkinson_seq #(.NUM_CH(NCH), .NUM_QTY(NQ), .CNT_W(CW)) u0 (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .cmpIn    (cmpIn),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .rampEn   (rampEn),
    .busy     (busy),
    .done     (done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearStim();
    for (int e = 0; e < NE; e++) begin
      tgt[e] = -1; fallK[e] = -1; riseK[e] = -1;
    end
  endtask

  task automatic readAll(input string req);
    for (int e = 0; e < NE; e++) begin
      @(negedge clk);
      rdAddr = AW'(e);
      #1;
      check(req, int'(rdData), (tgt[e] >= 0 && tgt[e] <= MAXV) ? tgt[e] : MAXV);
    end
  endtask

  // One full conversion; k counts cycles after the accepting edge (== count)
  task automatic doConv(input bit extraStart, input bit chkPreset);
    @(negedge clk);
    for (int e = 0; e < NE; e++) if (tgt[e] == -2) cmpIn[e] = 1'b1;
    repeat (4) @(negedge clk);
    rdAddr = '0;
    startReq = 1'b1;
    @(posedge clk);
    for (int k = 0; k <= MAXV + 3; k++) begin
      @(negedge clk);
      startReq = (extraStart && k == 5) ? 1'b1 : 1'b0;
      for (int e = 0; e < NE; e++) begin
        if (tgt[e] == k)   cmpIn[e] = 1'b1;
        if (fallK[e] == k) cmpIn[e] = 1'b0;
        if (riseK[e] == k) cmpIn[e] = 1'b1;
      end
      if (k == 0) begin
        check("R2 ramp at start", int'(rampEn), 1);
        check("R2 busy at start", int'(busy), 1);
        check("R10 done cleared", int'(done), 0);
        if (chkPreset) check("R10 preset", int'(rdData), MAXV);
      end
      if (k == MAXV)     check("R3 ramp at top", int'(rampEn), 1);
      if (k == MAXV + 1) begin
        check("R3 ramp off after top", int'(rampEn), 0);
        check("R3 busy in flush", int'(busy), 1);
      end
      if (k == MAXV + 2) check("R7 no early done", int'(done), 0);
      if (k == MAXV + 3) begin
        check(extraStart ? "R8 done timing" : "R7 done", int'(done), 1);
        check("R7 busy low", int'(busy), 0);
      end
    end
  endtask

  task automatic finishConv();
    @(negedge clk);
    cmpIn = '0;
    repeat (3) @(negedge clk);
    check("R7 done held", int'(done), 1);
  endtask

  task automatic testReset();
    check("R1 ramp", int'(rampEn), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    for (int e = 0; e < NE; e++) begin
      rdAddr = AW'(e);
      #1;
      check("R1 result full scale", int'(rdData), MAXV);
    end
  endtask

  // R4, R6, R9: assorted crossings incl. both scale ends, one silent entry
  task automatic testBasic();
    clearStim();
    tgt[0] = 0; tgt[1] = 17; tgt[2] = MAXV; tgt[3] = 40; tgt[4] = -1; tgt[5] = 1;
    doConv(1'b0, 1'b0);
    readAll("R4/R9 capture");
    finishConv();
  endtask

  // R5: glitching comparators; R6: comparator high before start; R10 preset
  task automatic testGlitch();
    clearStim();
    tgt[0] = 10; fallK[0] = 12; riseK[0] = 20;
    tgt[1] = 30; fallK[1] = 31; riseK[1] = 32;
    tgt[2] = -2;
    tgt[4] = 62;
    doConv(1'b0, 1'b1);
    readAll("R5/R6 first edge");
    finishConv();
  endtask

  // R8: start pulse in mid-run is ignored
  task automatic testBusyStart();
    clearStim();
    tgt[0] = 2; tgt[1] = 50; tgt[5] = MAXV; tgt[3] = 7;
    doConv(1'b1, 1'b1);
    readAll("R8 results unchanged");
    finishConv();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testBasic();
    testGlitch();
    testBusyStart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule